// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block turns single-byte memory requests into external bus cycles of the classic multiplexed kind. The bus has one shared byte lane for low address and data, a second byte lane for the high address, an address-latch strobe (ALE) and three active-low strobes: program-store for code fetches, and read and write for data accesses. The block runs from a master clock whose period is one oscillator period, and every strobe phase is a whole number of these clocks. External glue latches the low address byte from the shared lane when ALE falls.

A request enters on a valid/ready handshake carrying a kind code, a 16-bit address and write data. The request is accepted on a rising edge where both `req_valid` and `req_ready` are high. The requester must hold `req_valid` and the request fields stable until that edge. `req_ready` is high while the sequencer is idle and in the last clock of a running cycle, so a waiting request follows with no gap. The response side has no back-pressure: `rsp_done` pulses for one clock when a cycle finishes, and `rsp_rdata` holds the most recently captured read byte. A plain control input, `ale_quiet`, keeps ALE low while no external cycle runs. When `ale_quiet` is clear, ALE keeps its machine-cycle rhythm through idle time.

Top module: `ebus_seq`

## Requirements
- R1: After a synchronous reset, ALE is low, PSEN#, RD# and WR# are high, the shared lane is not driven (`lane_oe` = 0), `req_ready` is 1, `rsp_done` is 0 and `rsp_rdata` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when idle and in the final clock of a cycle, so queued requests run back to back. The kind code is 0 for a code fetch, 1 for a data read, 2 for a data write, and 3 for a data read.
- R3: Clocks of a cycle are numbered from 0, where clock 0 is the first clock after acceptance. ALE is high in clocks 0 and 1 of every cycle and low for the rest of the cycle. ALE is never high while any of PSEN#, RD# or WR# is low.
- R4: A code fetch lasts 6 clocks. PSEN# is low in clocks 3 to 5, and RD# and WR# stay high.
- R5: A data cycle lasts 12 clocks. Its strobe, RD# for a read and WR# for a write, is low in clocks 5 to 10. At most one of the three strobes is low at any time.
- R6: On a fetch, the shared lane carries address bits 7:0 in clocks 0 to 2 and is then released. On a read, it carries them in clocks 0 to 4 and is released from clock 5. `lane_in` is captured on the edge that ends the last strobe-low clock.
- R7: On a write, the shared lane carries address bits 7:0 in clocks 0 to 3 and the write byte in clocks 4 to 11, unchanged while WR# is low.
- R8: The high lane carries address bits 15:8 throughout every cycle, including the final clock. It keeps that value until the next request is accepted.
- R9: `rsp_done` is high for exactly the one clock after a cycle's last clock, and `rsp_rdata` then holds the captured byte. A write completes with `rsp_done` and leaves `rsp_rdata` unchanged.
- R10: While `ale_quiet` is 1, ALE stays low in every idle clock. Cycles still drive ALE as in R3.
- R11: While `ale_quiet` is 0, ALE in idle follows a 6-clock pattern of 2 high and 4 low. The pattern starts high in the first idle clock after a cycle. After reset, the pattern starts with the 4 low clocks.
- R12: A reset during a cycle ends the cycle at once and leaves the pins and handshake as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, one oscillator period |
| rst | input | 1 | Synchronous reset, active high |
| ale_quiet | input | 1 | Hold ALE low while idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | External address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Last captured read or fetch byte |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| hi_lane | output | 8 | High address byte lane |
| lane_out | output | 8 | Shared lane outgoing value |
| lane_oe | output | 1 | Shared lane drive enable |
| lane_in | input | 8 | Shared lane incoming value |

## Verification
The bench builds the block with its default parameters. These give 8-bit lanes, a 2-clock ALE pulse, 6-clock fetches, 12-clock data cycles and a 6-clock idle rhythm. With these short lengths, chains of back-to-back cycles of mixed kinds, several full periods of the idle ALE pattern in both settings of `ale_quiet`, and a reset in the middle of a write all fit in a few hundred clocks. The high and low address bytes differ in every request, and a memory model returns a byte that depends on both latched halves, so a swapped lane, a late latch or a capture on the wrong clock shows up as wrong read data.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  // Request kind codes as seen on req_kind.
  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_RDALT = 2'd3
  } cyc_kind_e;

endpackage

// File: rtl/ebus_phase_timer.sv
module ebus_phase_timer #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] cyc_len,
  output logic          busy,
  output logic [PW-1:0] phase,
  output logic          fin
);

  // Final clock of the running cycle.
  assign fin = busy && (phase == (cyc_len - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (fin) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (busy) begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/ebus_strobe_dec.sv
module ebus_strobe_dec
  import ebus_pkg::*;
#(
  parameter int PW        = 4,
  parameter int ALE_CLKS  = 2,
  parameter int FETCH_GAP = 1,
  parameter int FETCH_STB = 3,
  parameter int DATA_GAP  = 3,
  parameter int DATA_STB  = 6,
  parameter int STB_TAIL  = 1,
  parameter int WR_SETUP  = 1
) (
  input  logic          busy,
  input  cyc_kind_e     kind,
  input  logic [PW-1:0] phase,
  output logic          ale_cyc,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          addr_en,
  output logic          data_en,
  output logic          cap,
  output logic [PW-1:0] cyc_len
);

  localparam int FS_BEG    = ALE_CLKS + FETCH_GAP;
  localparam int FS_END    = FS_BEG + FETCH_STB;
  localparam int FETCH_LEN = FS_END;
  localparam int DS_BEG    = ALE_CLKS + DATA_GAP;
  localparam int DS_END    = DS_BEG + DATA_STB;
  localparam int DATA_LEN  = DS_END + STB_TAIL;
  localparam int WD_BEG    = DS_BEG - WR_SETUP;

  logic is_fetch, is_write, is_read;
  logic in_fstb, in_dstb;

  always_comb begin
    is_fetch = (kind == CYC_FETCH);
    is_write = (kind == CYC_WRITE);
    is_read  = !is_fetch && !is_write;

    in_fstb = (phase >= PW'(FS_BEG)) && (phase < PW'(FS_END));
    in_dstb = (phase >= PW'(DS_BEG)) && (phase < PW'(DS_END));

    ale_cyc = busy && (phase < PW'(ALE_CLKS));
    psen_n  = !(busy && is_fetch && in_fstb);
    rd_n    = !(busy && is_read  && in_dstb);
    wr_n    = !(busy && is_write && in_dstb);

    if (is_fetch)      addr_en = busy && (phase < PW'(FS_BEG));
    else if (is_write) addr_en = busy && (phase < PW'(WD_BEG));
    else               addr_en = busy && (phase < PW'(DS_BEG));

    data_en = busy && is_write && (phase >= PW'(WD_BEG));

    if (is_fetch) cap = busy && (phase == PW'(FS_END - 1));
    else          cap = busy && is_read && (phase == PW'(DS_END - 1));

    cyc_len = is_fetch ? PW'(FETCH_LEN) : PW'(DATA_LEN);
  end

endmodule

// File: rtl/ebus_idle_ale.sv
module ebus_idle_ale #(
  parameter int IDLE_PERIOD = 6,
  parameter int ALE_CLKS    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  output logic ale_idle
);

  localparam int IW = (IDLE_PERIOD > 1) ? $clog2(IDLE_PERIOD) : 1;

  logic [IW-1:0] cnt;

  // High in the first ALE_CLKS slots of each idle period.
  assign ale_idle = (cnt < IW'(ALE_CLKS));

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= IW'(ALE_CLKS);
    else if (busy)
      cnt <= '0;
    else if (cnt == IW'(IDLE_PERIOD - 1))
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ebus_lane.sv
module ebus_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [2*DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          addr_en,
  input  logic          data_en,
  input  logic          cap,
  input  logic [DW-1:0] lane_in,
  output logic [DW-1:0] hi_lane,
  output logic [DW-1:0] lane_out,
  output logic          lane_oe,
  output logic [DW-1:0] rdata
);

  logic [2*DW-1:0] addr_q;
  logic [DW-1:0]   wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      if (load) begin
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      if (cap)
        rdata <= lane_in;
    end
  end

  assign hi_lane  = addr_q[2*DW-1:DW];
  assign lane_oe  = addr_en || data_en;
  assign lane_out = addr_en ? addr_q[DW-1:0] : (data_en ? wdata_q : '0);

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int DW          = 8,
  parameter int ALE_CLKS    = 2,
  parameter int FETCH_GAP   = 1,
  parameter int FETCH_STB   = 3,
  parameter int DATA_GAP    = 3,
  parameter int DATA_STB    = 6,
  parameter int STB_TAIL    = 1,
  parameter int WR_SETUP    = 1,
  parameter int IDLE_PERIOD = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale_quiet,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [2*DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] hi_lane,
  output logic [DW-1:0] lane_out,
  output logic          lane_oe,
  input  logic [DW-1:0] lane_in
);

  localparam int FETCH_LEN = ALE_CLKS + FETCH_GAP + FETCH_STB;
  localparam int DATA_LEN  = ALE_CLKS + DATA_GAP + DATA_STB + STB_TAIL;
  localparam int MAX_LEN   = (FETCH_LEN > DATA_LEN) ? FETCH_LEN : DATA_LEN;
  localparam int PW        = $clog2(MAX_LEN + 1);

  logic          busy, fin, accept;
  logic [PW-1:0] phase, cyc_len;
  cyc_kind_e     kind_q;
  logic          ale_cyc, ale_idle, addr_en, data_en, cap;

  assign req_ready = !busy || fin;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= CYC_FETCH;
      rsp_done <= 1'b0;
    end else begin
      if (accept)
        kind_q <= cyc_kind_e'(req_kind);
      rsp_done <= fin;
    end
  end

  ebus_phase_timer #(.PW(PW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .cyc_len (cyc_len),
    .busy    (busy),
    .phase   (phase),
    .fin     (fin)
  );

  ebus_strobe_dec #(
    .PW        (PW),
    .ALE_CLKS  (ALE_CLKS),
    .FETCH_GAP (FETCH_GAP),
    .FETCH_STB (FETCH_STB),
    .DATA_GAP  (DATA_GAP),
    .DATA_STB  (DATA_STB),
    .STB_TAIL  (STB_TAIL),
    .WR_SETUP  (WR_SETUP)
  ) u_dec (
    .busy    (busy),
    .kind    (kind_q),
    .phase   (phase),
    .ale_cyc (ale_cyc),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr_en (addr_en),
    .data_en (data_en),
    .cap     (cap),
    .cyc_len (cyc_len)
  );

  ebus_idle_ale #(
    .IDLE_PERIOD (IDLE_PERIOD),
    .ALE_CLKS    (ALE_CLKS)
  ) u_idle (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .ale_idle (ale_idle)
  );

  ebus_lane #(.DW(DW)) u_lane (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .addr_en  (addr_en),
    .data_en  (data_en),
    .cap      (cap),
    .lane_in  (lane_in),
    .hi_lane  (hi_lane),
    .lane_out (lane_out),
    .lane_oe  (lane_oe),
    .rdata    (rsp_rdata)
  );

  assign ale = busy ? ale_cyc : (ale_idle && !ale_quiet);

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ale_quiet,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          ale,
  input logic          psen_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [DW-1:0] hi_lane,
  input logic [DW-1:0] lane_out,
  input logic          lane_oe
);

  logic any_stb;
  assign any_stb = !psen_n || !rd_n || !wr_n;

  // R3
  ale_off_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    any_stb |-> !ale);

  // R4
  psen_after_ale_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |-> (!$past(ale) && $past(ale, 2)));

  // R5
  data_stb_after_ale_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) || $fell(wr_n)) |->
      (!$past(ale) && !$past(ale, 2) && !$past(ale, 3) && $past(ale, 4)));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({psen_n, rd_n, wr_n}) >= 2);

  // R6
  lane_free_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !lane_oe);

  // R7
  wdata_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && $past(!wr_n)) |-> (lane_oe && $stable(lane_out)));

  // R8
  hi_lane_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (any_stb && $past(any_stb)) |-> $stable(hi_lane));

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R10
  quiet_idle_ale_chk: assert property (@(posedge clk) disable iff (rst)
    (ale_quiet && req_ready) |-> !ale);

endmodule

bind ebus_seq ebus_seq_chk #(.DW(DW)) u_ebus_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .ale_quiet (ale_quiet),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .hi_lane   (hi_lane),
  .lane_out  (lane_out),
  .lane_oe   (lane_oe)
);

// File: tb/tb_ebus_seq.sv
module tb_ebus_seq;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        ale_quiet = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic        ale, psen_n, rd_n, wr_n, lane_oe;
  logic [7:0]  hi_lane, lane_out, lane_in;

  ebus_seq dut (
    .clk(clk), .rst(rst), .ale_quiet(ale_quiet),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .hi_lane(hi_lane), .lane_out(lane_out), .lane_oe(lane_oe),
    .lane_in(lane_in)
  );

  typedef struct {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } req_t;

  req_t pin_q[$];
  req_t done_q[$];

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit ended = 1'b0;

  // External memory model: byte depends on both latched halves.
  function automatic logic [7:0] mem_f(input logic [7:0] hi, input logic [7:0] lo);
    return hi ^ {lo[3:0], lo[7:4]} ^ 8'h3C;
  endfunction

  logic [7:0] lat_lo = 8'h00;
  always @(negedge ale) lat_lo <= lane_out;
  assign lane_in = (!psen_n || !rd_n) ? mem_f(hi_lane, lat_lo) : 8'h00;

  task automatic chk(input string tag, input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: present one request, hold it until taken, record the expectation.
  task automatic send(input logic [1:0] k, input logic [15:0] a, input logic [7:0] w);
    bit ok;
    req_t r;
    r.kind = k; r.addr = a; r.wdata = w;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w;
    do begin
      #1;
      ok = req_ready;
      if (ok) begin
        pin_q.push_back(r);
        done_q.push_back(r);
      end
      @(negedge clk);
    end while (!ok);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard: bench-side model of the cycle timing.
  bit         active = 1'b0;
  int         t = 0;
  int         len = 0;
  int         idle_i = 2;
  bit         done_pend = 1'b0;
  req_t       cur;
  logic [7:0] last_rd = 8'h00;
  logic [7:0] last_hi = 8'h00;

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!mon_en) begin
        active = 1'b0; t = 0; idle_i = 2; done_pend = 1'b0;
        last_rd = 8'h00; last_hi = 8'h00;
        pin_q.delete(); done_q.delete();
      end else begin
        bit isf, isw, isr;
        bit ale_e, ps_e, rd_e, wr_e, oe_e, rdy_e;
        logic [7:0] ln_e;
        string atag, ltag;
        isf = active && (cur.kind == 2'd0);
        isw = active && (cur.kind == 2'd2);
        isr = active && !isf && !isw;
        ps_e = 1'b1; rd_e = 1'b1; wr_e = 1'b1; oe_e = 1'b0; ln_e = 8'h00;
        if (active) begin
          ale_e = (t < 2);
          atag = "R3";
          rdy_e = (t == len - 1);
          if (isf) begin
            ps_e = !(t >= 3 && t < 6);
            oe_e = (t < 3); ln_e = cur.addr[7:0];
            ltag = "R6";
          end else if (isr) begin
            rd_e = !(t >= 5 && t < 11);
            oe_e = (t < 5); ln_e = cur.addr[7:0];
            ltag = "R6";
          end else begin
            wr_e = !(t >= 5 && t < 11);
            oe_e = 1'b1;
            ln_e = (t < 4) ? cur.addr[7:0] : cur.wdata;
            ltag = "R7";
          end
        end else begin
          ale_e = !ale_quiet && (idle_i < 2);
          atag = ale_quiet ? "R10" : "R11";
          rdy_e = 1'b1;
          ltag = "R6";
        end
        chk(atag, ale == ale_e, "ale", 32'(ale), 32'(ale_e));
        chk("R4", psen_n == ps_e, "psen_n", 32'(psen_n), 32'(ps_e));
        chk("R5", {rd_n, wr_n} == {rd_e, wr_e}, "rd_n/wr_n", 32'({rd_n, wr_n}), 32'({rd_e, wr_e}));
        chk(ltag, lane_oe == oe_e, "lane_oe", 32'(lane_oe), 32'(oe_e));
        if (oe_e)
          chk(ltag, lane_out == ln_e, "lane_out", 32'(lane_out), 32'(ln_e));
        chk("R8", hi_lane == last_hi, "hi_lane", 32'(hi_lane), 32'(last_hi));
        chk("R2", req_ready == rdy_e, "req_ready", 32'(req_ready), 32'(rdy_e));
        chk("R9", rsp_done == done_pend, "rsp_done", 32'(rsp_done), 32'(done_pend));
        if (rsp_done && done_q.size() > 0) begin
          req_t d;
          logic [7:0] rexp;
          d = done_q.pop_front();
          rexp = (d.kind == 2'd2) ? last_rd : mem_f(d.addr[15:8], d.addr[7:0]);
          chk((d.kind == 2'd2) ? "R9" : "R6", rsp_rdata == rexp, "rsp_rdata",
              32'(rsp_rdata), 32'(rexp));
          last_rd = rexp;
        end
        // Advance the model to the next clock.
        done_pend = active && (t == len - 1);
        if (req_valid && req_ready && pin_q.size() > 0) begin
          cur = pin_q.pop_front();
          active = 1'b1; t = 0;
          len = (cur.kind == 2'd0) ? 6 : 12;
          last_hi = cur.addr[15:8];
        end else if (active && t == len - 1) begin
          active = 1'b0; idle_i = 0;
        end else if (active) begin
          t++;
        end else begin
          idle_i = (idle_i == 5) ? 0 : idle_i + 1;
        end
      end
    end
  end

  task automatic check_reset_state(input string tag);
    #3;
    chk(tag, ale == 1'b0, "ale after reset", 32'(ale), 32'h0);
    chk(tag, {psen_n, rd_n, wr_n} == 3'b111, "strobes after reset", 32'({psen_n, rd_n, wr_n}), 32'h7);
    chk(tag, lane_oe == 1'b0, "lane_oe after reset", 32'(lane_oe), 32'h0);
    chk(tag, req_ready == 1'b1, "req_ready after reset", 32'(req_ready), 32'h1);
    chk(tag, rsp_done == 1'b0, "rsp_done after reset", 32'(rsp_done), 32'h0);
    chk(tag, rsp_rdata == 8'h00, "rsp_rdata after reset", 32'(rsp_rdata), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    mon_en = 1'b0;
    idle(3);
    rst = 1'b0;
    mon_en = 1'b1;
    check_reset_state("R1");
    @(negedge clk);

    // R10: quiet idle, single cycles of each kind
    ale_quiet = 1'b1;
    idle(4);
    send(2'd0, 16'h1234, 8'h00);
    idle(8);
    send(2'd1, 16'hABCD, 8'h00);
    idle(14);
    send(2'd2, 16'h5A0F, 8'hC3);
    idle(14);
    // R2: back-to-back chain of mixed kinds, and kind 3 as a read
    send(2'd0, 16'h0102, 8'h00);
    send(2'd0, 16'hF0E1, 8'h00);
    send(2'd1, 16'h3377, 8'h00);
    send(2'd2, 16'h9988, 8'h5E);
    send(2'd3, 16'h6C21, 8'h00);
    send(2'd0, 16'h7F80, 8'h00);
    idle(20);

    // R11: free-running idle ALE
    ale_quiet = 1'b0;
    idle(15);
    send(2'd0, 16'h2468, 8'h00);
    idle(9);
    send(2'd2, 16'h1357, 8'hA9);
    send(2'd1, 16'hFEDC, 8'h00);
    idle(20);

    // R12: reset in the middle of a write
    send(2'd2, 16'h7777, 8'h11);
    idle(5);
    mon_en = 1'b0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    mon_en = 1'b1;
    check_reset_state("R12");
    @(negedge clk);
    send(2'd1, 16'h4A4B, 8'h00);
    idle(20);

    chk("R9", done_q.size() == 0, "pending completions", 32'(done_q.size()), 32'h0);
    finish_run();
  end

endmodule